// File: doc/BRIEF.md
# Bounded Downward-Growing Stack Unit

This block is a self-contained hardware stack. It holds a 16-bit stack pointer and owns a small word memory. The stack grows toward lower addresses. A client raises a push request with a data word, or a pop request. One clock edge later the unit raises a one-cycle completion pulse and a one-bit status. The status is 0 when the operation succeeded and 1 when it was refused. After a successful pop, the popped word is also presented.

The pointer moves between two fixed addresses. The empty value is x3000, which is one word above the base word x2FFF. The lowest usable word is x0200. A push made when the pointer already sits at x0200 is refused. A pop made from an empty stack is also refused. A refused operation leaves the pointer and the memory as they were.

The memory is modelled in reduced form: an array indexed by the low pointer bits. Addresses that share those bits map to the same word, so pop data matches the push order only while the stack is shallower than the array. A request may be presented on every cycle, and each one is serviced in turn.

Top module: `dstack_unit`

## Requirements
- R1: While reset is held and after it is released, the pointer output reads x3000 and the completion and status outputs read 0. The pointer never leaves the range x0200 to x3000.
- R2: A push with the pointer above x0200 lowers the pointer by one and writes the data word at the new pointer address. The cycle after the request shows completion 1 and status 0.
- R3: A push with the pointer equal to x0200 is refused. The cycle after the request shows completion 1 and status 1, with the pointer unchanged. The top word still pops back intact afterwards.
- R4: A pop with the pointer below x3000 reads the word at the current pointer address and then raises the pointer by one. The cycle after the request shows completion 1, status 0 and the popped word. Words come back last-in first-out.
- R5: A pop with the pointer equal to x3000 is refused. The cycle after the request shows completion 1 and status 1, with the pointer and the data output unchanged.
- R6: Push and pop raised together are refused with completion 1 and status 1. The pointer and the stored words are unchanged.
- R7: Completion is a one-cycle pulse for each request. In a cycle with no request, completion is 0 one cycle later.
- R8: Requests on consecutive cycles are each serviced, one result per cycle, with no idle cycle required between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset, asynchronous active low, released synchronously inside the block |
| push_i | input | 1 | Push request for this cycle |
| pop_i | input | 1 | Pop request for this cycle |
| wdata_i | input | 16 | Word to push |
| done_o | output | 1 | One-cycle completion pulse for the request of the previous cycle |
| fail_o | output | 1 | Status with done_o: 0 means success, 1 means refused |
| rdata_o | output | 16 | Word from the last successful pop |
| sp_o | output | 16 | Current stack pointer |

## Verification
Every result of this unit is due exactly one clock edge after the request is sampled. This covers the completion pulse, the status bit, the popped word and the new pointer. The bench drives each request on a falling edge and compares all outputs on the next falling edge, so it samples after the single register stage and before the following request takes effect. After reset is released, the internal two-flop release stage delays operation, so the bench waits several cycles before its first request. The limit case is reached by back-to-back pushes, and the pointer is checked only after the last of them.

// File: rtl/dstack_pkg.sv
package dstack_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 16;
  localparam int MEM_IDX_W = 6;
  localparam logic [ADDR_W-1:0] EMPTY_SP = 16'h3000;
  localparam logic [ADDR_W-1:0] LIMIT_SP = 16'h0200;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_PUSH   = 2'd1,
    OP_POP    = 2'd2,
    OP_REJECT = 2'd3
  } op_e;
endpackage

// File: rtl/dstack_rst_sync.sv
module dstack_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/dstack_ctrl.sv
module dstack_ctrl
  import dstack_pkg::*;
#(
  parameter int               AW    = ADDR_W,
  parameter logic [AW-1:0]    EMPTY = EMPTY_SP,
  parameter logic [AW-1:0]    LIMIT = LIMIT_SP
) (
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] sp_i,
  output op_e           op_o,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] sp_nxt_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic at_limit;
  logic at_empty;

  assign at_limit = (sp_i == LIMIT);
  assign at_empty = (sp_i == EMPTY);

  always_comb begin
    op_o     = OP_IDLE;
    addr_o   = sp_i;
    sp_nxt_o = sp_i;
    if (push_i && pop_i) begin
      op_o = OP_REJECT;
    end else if (push_i) begin
      if (at_limit) begin
        op_o = OP_REJECT;
      end else begin
        op_o     = OP_PUSH;
        addr_o   = sp_i - ONE;
        sp_nxt_o = sp_i - ONE;
      end
    end else if (pop_i) begin
      if (at_empty) begin
        op_o = OP_REJECT;
      end else begin
        op_o     = OP_POP;
        addr_o   = sp_i;
        sp_nxt_o = sp_i + ONE;
      end
    end
  end
endmodule

// File: rtl/dstack_mem.sv
module dstack_mem #(
  parameter int DW   = 16,
  parameter int IDXW = 6
) (
  input  logic            clk,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o
);
  localparam int DEPTH = 1 << IDXW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en_i) begin
      rdata_q <= mem_q[idx_i];
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/dstack_unit.sv
module dstack_unit
  import dstack_pkg::*;
#(
  parameter int            AW    = ADDR_W,
  parameter int            DW    = DATA_W,
  parameter int            IDXW  = MEM_IDX_W,
  parameter logic [AW-1:0] EMPTY = EMPTY_SP,
  parameter logic [AW-1:0] LIMIT = LIMIT_SP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic          done_o,
  output logic          fail_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] sp_o
);
  logic          rst_sync_n;
  op_e           op;
  logic [AW-1:0] addr;
  logic [AW-1:0] sp_nxt;

  logic [AW-1:0] sp_q, sp_d;
  logic          sp_en;
  logic          done_q, done_d;
  logic          fail_q, fail_d;
  logic          wr_en, rd_en;

  dstack_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dstack_ctrl #(
    .AW    (AW),
    .EMPTY (EMPTY),
    .LIMIT (LIMIT)
  ) u_ctrl (
    .push_i   (push_i),
    .pop_i    (pop_i),
    .sp_i     (sp_q),
    .op_o     (op),
    .addr_o   (addr),
    .sp_nxt_o (sp_nxt)
  );

  // Next-state logic
  always_comb begin
    wr_en  = (op == OP_PUSH);
    rd_en  = (op == OP_POP);
    sp_en  = wr_en || rd_en;
    sp_d   = sp_nxt;
    done_d = push_i || pop_i;
    fail_d = (op == OP_REJECT);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sp_q   <= EMPTY;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      if (sp_en) begin
        sp_q <= sp_d;
      end
      done_q <= done_d;
      fail_q <= fail_d;
    end
  end

  dstack_mem #(
    .DW   (DW),
    .IDXW (IDXW)
  ) u_mem (
    .clk     (clk),
    .wr_en_i (wr_en && rst_sync_n),
    .rd_en_i (rd_en && rst_sync_n),
    .idx_i   (addr[IDXW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o)
  );

  assign done_o = done_q;
  assign fail_o = fail_q;
  assign sp_o   = sp_q;
endmodule

// File: rtl/dstack_chk.sv
module dstack_chk
  import dstack_pkg::*;
#(
  parameter int            AW    = ADDR_W,
  parameter int            DW    = DATA_W,
  parameter logic [AW-1:0] EMPTY = EMPTY_SP,
  parameter logic [AW-1:0] LIMIT = LIMIT_SP
) (
  input logic          clk,
  input logic          rst_ok,
  input logic          push_i,
  input logic          pop_i,
  input logic          done_o,
  input logic          fail_o,
  input logic [DW-1:0] rdata_o,
  input logic [AW-1:0] sp_o
);
  a_r1_sp_in_range: assert property (@(posedge clk) disable iff (!rst_ok)
    (sp_o <= EMPTY) && (sp_o >= LIMIT));

  a_r2_push_moves_down: assert property (@(posedge clk) disable iff (!rst_ok)
    (push_i && !pop_i && sp_o != LIMIT) |=>
      (sp_o == $past(sp_o) - AW'(1)) && done_o && !fail_o);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_ok)
    (push_i && !pop_i && sp_o == LIMIT) |=> done_o && fail_o && $stable(sp_o));

  a_r4_pop_moves_up: assert property (@(posedge clk) disable iff (!rst_ok)
    (pop_i && !push_i && sp_o != EMPTY) |=>
      (sp_o == $past(sp_o) + AW'(1)) && done_o && !fail_o);

  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_ok)
    (pop_i && !push_i && sp_o == EMPTY) |=>
      done_o && fail_o && $stable(sp_o) && $stable(rdata_o));

  a_r6_dual_refused: assert property (@(posedge clk) disable iff (!rst_ok)
    (push_i && pop_i) |=> done_o && fail_o && $stable(sp_o));

  a_r7_idle_no_done: assert property (@(posedge clk) disable iff (!rst_ok)
    (!push_i && !pop_i) |=> !done_o && !fail_o);

  a_r8_each_req_done: assert property (@(posedge clk) disable iff (!rst_ok)
    (push_i || pop_i) |=> done_o);
endmodule

bind dstack_unit dstack_chk #(
  .AW    (AW),
  .DW    (DW),
  .EMPTY (EMPTY),
  .LIMIT (LIMIT)
) u_chk (
  .clk     (clk),
  .rst_ok  (rst_sync_n),
  .push_i  (push_i),
  .pop_i   (pop_i),
  .done_o  (done_o),
  .fail_o  (fail_o),
  .rdata_o (rdata_o),
  .sp_o    (sp_o)
);

// File: tb/dstack_unit_tb_top.sv
`timescale 1ns/1ps
module dstack_unit_tb_top;
  localparam time CLK_PER = 20ns;
  localparam int  VW      = 53;
  localparam int  NV      = 10;
  localparam int  NFILL   = 16'h2E00;

  // Vector fields, MSB first:
  // push, pop, wdata[16], exp_done, exp_fail, exp_rdata[16], chk_rdata, exp_sp[16]
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 1'b1, 16'h0000, 1'b1, 1'b1, 16'h0000, 1'b0, 16'h3000}, // R5 pop empty
    {1'b1, 1'b0, 16'hA111, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h2FFF}, // R2
    {1'b1, 1'b0, 16'hB222, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h2FFE}, // R2 R8
    {1'b1, 1'b1, 16'hDEAD, 1'b1, 1'b1, 16'h0000, 1'b0, 16'h2FFE}, // R6
    {1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h2FFE}, // R7 idle
    {1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 16'hB222, 1'b1, 16'h2FFF}, // R4 R6
    {1'b1, 1'b0, 16'hC333, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h2FFE}, // R2 R8
    {1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 16'hC333, 1'b1, 16'h2FFF}, // R4 R8
    {1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 16'hA111, 1'b1, 16'h3000}, // R4
    {1'b0, 1'b1, 16'h0000, 1'b1, 1'b1, 16'hA111, 1'b1, 16'h3000}  // R5 data held
  };

  logic        clk;
  logic        rst_n;
  logic        push_i;
  logic        pop_i;
  logic [15:0] wdata_i;
  logic        done_o;
  logic        fail_o;
  logic [15:0] rdata_o;
  logic [15:0] sp_o;

  int n_cmp;
  int n_bad;
  bit finished;

  dstack_unit dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .wdata_i (wdata_i),
    .done_o  (done_o),
    .fail_o  (fail_o),
    .rdata_o (rdata_o),
    .sp_o    (sp_o)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PER * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [VW-1:0] v;
    n_cmp    = 0;
    n_bad    = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    push_i   = 1'b0;
    pop_i    = 1'b0;
    wdata_i  = '0;
    repeat (3) @(negedge clk);
    check("R1", "sp in reset", 32'(sp_o), 32'h3000);
    check("R1", "done in reset", 32'(done_o), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "sp after release", 32'(sp_o), 32'h3000);
    check("R1", "fail after release", 32'(fail_o), 32'h0);

    // Table walk: drive on a falling edge, compare on the next one
    for (int i = 0; i < NV; i++) begin
      v       = VEC[i];
      push_i  = v[52];
      pop_i   = v[51];
      wdata_i = v[50:35];
      @(negedge clk);
      check("R2/R4/R5/R6/R7/R8", $sformatf("vec %0d done", i), 32'(done_o), 32'(v[34]));
      check("R2/R4/R5/R6/R7/R8", $sformatf("vec %0d fail", i), 32'(fail_o), 32'(v[33]));
      check("R2/R4/R5/R6/R8", $sformatf("vec %0d sp", i), 32'(sp_o), 32'(v[15:0]));
      if (v[16]) begin
        check("R4/R5", $sformatf("vec %0d rdata", i), 32'(rdata_o), 32'(v[32:17]));
      end
    end

    // R3: fill to the limit with back-to-back pushes
    push_i = 1'b1;
    pop_i  = 1'b0;
    for (int i = 0; i < NFILL; i++) begin
      wdata_i = 16'(i);
      @(negedge clk);
    end
    check("R3", "sp at limit", 32'(sp_o), 32'h0200);
    check("R8", "last fill push ok", 32'(fail_o), 32'h0);
    wdata_i = 16'hFFFF;
    @(negedge clk);
    check("R3", "overflow done", 32'(done_o), 32'h1);
    check("R3", "overflow fail", 32'(fail_o), 32'h1);
    check("R3", "overflow sp held", 32'(sp_o), 32'h0200);
    push_i = 1'b0;
    pop_i  = 1'b1;
    @(negedge clk);
    check("R3", "top word intact", 32'(rdata_o), 32'h2DFF);
    check("R3", "sp after pop", 32'(sp_o), 32'h0201);
    pop_i = 1'b0;
    @(negedge clk);
    check("R7", "done single pulse", 32'(done_o), 32'h0);

    // R1: reset mid-run returns the pointer to empty
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "sp on reset", 32'(sp_o), 32'h3000);
    check("R1", "fail on reset", 32'(fail_o), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    pop_i = 1'b1;
    @(negedge clk);
    check("R5", "pop after reset refused", 32'(fail_o), 32'h1);
    pop_i = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule